// File: doc/BRIEF.md
# Scratch Memory Load/Store Unit

This block owns a small byte-addressed scratch memory and serves one access per request over a valid/ready handshake. Each request carries a 5-bit opcode, a 32-bit base address, two 8-bit offsets and two 128-bit write-data operands. A load sends back up to four 32-bit words. A store sends back a response that carries no data. The unit performs single-address accesses of 1, 2, 4, 8 or 16 bytes. It also performs dual-address accesses, which move two independent 4-byte or 8-byte elements in one request. In the dual form each offset is scaled by the element size.

The memory holds 2^AW bytes, and every byte address wraps modulo that size. AW = 16 gives the full 64 KiB space. The default is smaller so that the default build stays light. The memory is built as sixteen byte-wide access slots, each with its own write enable, so every supported access finishes in the cycle it is accepted.

Control is a two-state machine. In ST_IDLE, `req_ready` is high. A request that is valid in ST_IDLE is accepted, which is the transition T_ACCEPT into ST_RESP. In ST_RESP, `rsp_valid` is high and `req_ready` is low. The machine then always returns to ST_IDLE, which is the transition T_DONE.

Top module: `lsm_unit`

## Requirements
- R1: After reset `req_ready`=1 and `rsp_valid`=0. A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is then high for exactly the next cycle, `req_ready` is low during that cycle, and `req_ready` is high again in the cycle after it.
- R2: A single-address access starts at (base + offset0) mod 2^AW. Byte k of the access sits at (base + offset0 + k) mod 2^AW, so an access wraps past the top of memory to address 0.
- R3: Opcodes 0 (unsigned byte), 1 (signed byte), 2 (unsigned halfword) and 3 (signed halfword) load into bits 7:0 or 15:0 of `rsp_data`. Unsigned forms zero-extend and signed forms sign-extend through bit 31. Bits 127:32 are zero.
- R4: Opcodes 9 (byte store) and 10 (halfword store) write only bits 7:0 or 15:0 of `req_data0`. Neighbouring bytes keep their values.
- R5: Opcodes 4, 5 and 6 load 4, 8 and 16 bytes. Opcodes 11, 12 and 13 store 4, 8 and 16 bytes from `req_data0`. Order is little-endian: byte k of the access sits at bits 8k+7:8k, so dword i comes from address + 4i. Result bits beyond the access width are zero.
- R6: The dual forms are opcodes 7 and 14 (4-byte elements) and opcodes 8 and 15 (8-byte elements). They use addr0 = base + offset0*size and addr1 = base + offset1*size, each taken mod 2^AW.
- R7: A dual load (opcode 7 or 8) returns the element at addr0 in the low `size` bytes of `rsp_data` and the element at addr1 in the next `size` bytes. With 8-byte elements, offsets 0 and 1 give bytes 0..7 and 8..15 with no overlap.
- R8: A dual store (opcode 14 or 15) writes the low `size` bytes of `req_data0` at addr0 and the low `size` bytes of `req_data1` at addr1. Where the two elements cover the same byte, the `req_data1` byte is kept.
- R9: Opcodes 16 to 31 are unsupported. They are accepted, leave memory unchanged, and respond with `rsp_err`=1 and `rsp_data`=0. Opcodes 0 to 15 respond with `rsp_err`=0.
- R10: A store response (opcodes 9 to 15) carries `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 5 | Operation code |
| req_base | input | 32 | Base byte address |
| req_off0 | input | 8 | First offset |
| req_off1 | input | 8 | Second offset (dual forms only) |
| req_data0 | input | 128 | Store data, first element |
| req_data1 | input | 128 | Store data, second element |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_err | output | 1 | Unsupported opcode flag |
| rsp_data | output | 128 | Load result, four 32-bit words |

## Verification
Two functions can fall into the same cycle: the writes of element 0 and element 1 of a dual store. They land on the same bytes when both offsets are equal, or when the scaled addresses wrap onto each other. Directed requests with equal offsets, including one near the top of memory, provoke this case. A later load reads the bytes back, and the result is judged against a bench model in which element 1 overwrites element 0. Random request mixes then stress the handshake, offset scaling and extension against the same model.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int SLOTS  = 16;
    localparam int DATA_W = SLOTS * 8;
    localparam int OP_W   = 5;

    localparam logic [OP_W-1:0] OP_LD_U8   = 5'd0;
    localparam logic [OP_W-1:0] OP_LD_S8   = 5'd1;
    localparam logic [OP_W-1:0] OP_LD_U16  = 5'd2;
    localparam logic [OP_W-1:0] OP_LD_S16  = 5'd3;
    localparam logic [OP_W-1:0] OP_LD_W1   = 5'd4;
    localparam logic [OP_W-1:0] OP_LD_W2   = 5'd5;
    localparam logic [OP_W-1:0] OP_LD_W4   = 5'd6;
    localparam logic [OP_W-1:0] OP_LDP_W1  = 5'd7;
    localparam logic [OP_W-1:0] OP_LDP_W2  = 5'd8;
    localparam logic [OP_W-1:0] OP_ST_8    = 5'd9;
    localparam logic [OP_W-1:0] OP_ST_16   = 5'd10;
    localparam logic [OP_W-1:0] OP_ST_W1   = 5'd11;
    localparam logic [OP_W-1:0] OP_ST_W2   = 5'd12;
    localparam logic [OP_W-1:0] OP_ST_W4   = 5'd13;
    localparam logic [OP_W-1:0] OP_STP_W1  = 5'd14;
    localparam logic [OP_W-1:0] OP_STP_W2  = 5'd15;

    typedef enum logic [1:0] {EXT_NONE, EXT_ZERO, EXT_SIGN} ext_e;

    typedef enum logic {ST_IDLE, ST_RESP} state_e;

    typedef struct packed {
        logic       legal;
        logic       store;
        logic       dual;
        logic [4:0] nbytes;   // access bytes, or element bytes when dual
        ext_e       ext;
    } dec_t;

    function automatic dec_t decode_op(input logic [OP_W-1:0] op);
        dec_t d;
        d = '{legal: 1'b1, store: 1'b0, dual: 1'b0, nbytes: 5'd4, ext: EXT_NONE};
        case (op)
            OP_LD_U8:  begin d.nbytes = 5'd1;  d.ext = EXT_ZERO; end
            OP_LD_S8:  begin d.nbytes = 5'd1;  d.ext = EXT_SIGN; end
            OP_LD_U16: begin d.nbytes = 5'd2;  d.ext = EXT_ZERO; end
            OP_LD_S16: begin d.nbytes = 5'd2;  d.ext = EXT_SIGN; end
            OP_LD_W1:  d.nbytes = 5'd4;
            OP_LD_W2:  d.nbytes = 5'd8;
            OP_LD_W4:  d.nbytes = 5'd16;
            OP_LDP_W1: begin d.nbytes = 5'd4;  d.dual = 1'b1; end
            OP_LDP_W2: begin d.nbytes = 5'd8;  d.dual = 1'b1; end
            OP_ST_8:   begin d.nbytes = 5'd1;  d.store = 1'b1; end
            OP_ST_16:  begin d.nbytes = 5'd2;  d.store = 1'b1; end
            OP_ST_W1:  begin d.nbytes = 5'd4;  d.store = 1'b1; end
            OP_ST_W2:  begin d.nbytes = 5'd8;  d.store = 1'b1; end
            OP_ST_W4:  begin d.nbytes = 5'd16; d.store = 1'b1; end
            OP_STP_W1: begin d.nbytes = 5'd4;  d.store = 1'b1; d.dual = 1'b1; end
            OP_STP_W2: begin d.nbytes = 5'd8;  d.store = 1'b1; d.dual = 1'b1; end
            default:   begin d.legal = 1'b0; d.nbytes = 5'd0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsm_addr_gen.sv
module lsm_addr_gen #(
    parameter int AW    = 10,
    parameter int SLOTS = 16
) (
    input  logic                         legal,
    input  logic                         dual,
    input  logic [4:0]                   nbytes,
    input  logic [31:0]                  base,
    input  logic [7:0]                   off0,
    input  logic [7:0]                   off1,
    input  logic [SLOTS*8-1:0]           data0,
    input  logic [SLOTS*8-1:0]           data1,
    output logic [SLOTS-1:0][AW-1:0]     slot_addr,
    output logic [SLOTS-1:0]             slot_en,
    output logic [SLOTS-1:0][7:0]        slot_wdata
);
    localparam int SEL_W = $clog2(SLOTS);

    logic [31:0] scale;
    logic [5:0]  span;

    assign scale = dual ? 32'(nbytes) : 32'd1;
    assign span  = dual ? (6'(nbytes) << 1) : 6'(nbytes);

    // Each slot carries one byte; in dual mode the upper slots belong to element 1.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic             elem1;
        logic [SEL_W-1:0] sel;
        always_comb begin
            elem1 = dual && (5'(k) >= nbytes);
            sel   = SEL_W'(5'(k) - nbytes);
            slot_en[k] = legal && (6'(k) < span);
            if (elem1) begin
                slot_addr[k]  = AW'(base + {24'b0, off1} * scale + 32'(k) - 32'(nbytes));
                slot_wdata[k] = data1[8*sel +: 8];
            end else begin
                slot_addr[k]  = AW'(base + {24'b0, off0} * scale + 32'(k));
                slot_wdata[k] = data0[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/lsm_load_fmt.sv
module lsm_load_fmt
    import lsm_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic [SLOTS-1:0][7:0] rd_bytes,
    input  logic [SLOTS-1:0]      slot_en,
    input  ext_e                  ext,
    input  logic [4:0]            nbytes,
    output logic [SLOTS*8-1:0]    ld_data
);
    logic [SLOTS-1:0][7:0] masked;

    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            masked[k] = slot_en[k] ? rd_bytes[k] : 8'h00;
        end
        unique case (ext)
            EXT_ZERO: begin
                if (nbytes == 5'd1) ld_data = (SLOTS*8)'(masked[0]);
                else                ld_data = (SLOTS*8)'({masked[1], masked[0]});
            end
            EXT_SIGN: begin
                if (nbytes == 5'd1) ld_data = (SLOTS*8)'({{24{masked[0][7]}}, masked[0]});
                else                ld_data = (SLOTS*8)'({{16{masked[1][7]}}, masked[1], masked[0]});
            end
            default:  ld_data = masked;
        endcase
    end

endmodule

// File: rtl/lsm_unit.sv
module lsm_unit
    import lsm_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [OP_W-1:0]     req_op,
    input  logic [31:0]         req_base,
    input  logic [7:0]          req_off0,
    input  logic [7:0]          req_off1,
    input  logic [DATA_W-1:0]   req_data0,
    input  logic [DATA_W-1:0]   req_data1,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam int DEPTH = 1 << AW;

    state_e state, state_nx;
    dec_t   dec;
    logic   accept;

    logic [SLOTS-1:0][AW-1:0] slot_addr;
    logic [SLOTS-1:0]         slot_en;
    logic [SLOTS-1:0][7:0]    slot_wdata;
    logic [SLOTS-1:0][7:0]    rd_bytes;
    logic [DATA_W-1:0]        ld_data;

    logic [7:0] mem [DEPTH];

    assign dec    = decode_op(req_op);
    assign accept = req_valid && req_ready;

    lsm_addr_gen #(.AW(AW), .SLOTS(SLOTS)) i_addr_gen (
        .legal      (dec.legal),
        .dual       (dec.dual),
        .nbytes     (dec.nbytes),
        .base       (req_base),
        .off0       (req_off0),
        .off1       (req_off1),
        .data0      (req_data0),
        .data1      (req_data1),
        .slot_addr  (slot_addr),
        .slot_en    (slot_en),
        .slot_wdata (slot_wdata)
    );

    for (genvar k = 0; k < SLOTS; k++) begin : g_rd
        assign rd_bytes[k] = mem[slot_addr[k]];
    end

    lsm_load_fmt #(.SLOTS(SLOTS)) i_load_fmt (
        .rd_bytes (rd_bytes),
        .slot_en  (slot_en),
        .ext      (dec.ext),
        .nbytes   (dec.nbytes),
        .ld_data  (ld_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: T_ACCEPT (IDLE->RESP), T_DONE (RESP->IDLE)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    // Handshake outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
        endcase
    end

    // Response payload captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data <= '0;
            rsp_err  <= 1'b0;
        end else if (accept) begin
            rsp_data <= (dec.legal && !dec.store) ? ld_data : '0;
            rsp_err  <= !dec.legal;
        end
    end

    // Byte writes in ascending slot order: element 1 wins on overlap
    always_ff @(posedge clk) begin
        if (accept && dec.store) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (slot_en[k]) mem[slot_addr[k]] <= slot_wdata[k];
            end
        end
    end

endmodule

// File: rtl/lsm_unit_chk.sv
module lsm_unit_chk
    import lsm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [OP_W-1:0]   req_op,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_data
);
    logic acc;
    assign acc = req_valid && req_ready;

    a_r1_busy_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r1_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    a_r1_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    a_r9_err_on_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op[4]) |=> (rsp_err && rsp_data == '0));

    a_r10_store_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op >= OP_ST_8 && req_op <= OP_STP_W2) |=> (rsp_data == '0 && !rsp_err));

    a_r3_zero_ext_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == OP_LD_U8) |=> (rsp_data[DATA_W-1:8] == '0));

    a_r3_sign_ext_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == OP_LD_S8) |=> (rsp_data[31:8] == {24{rsp_data[7]}} && rsp_data[DATA_W-1:32] == '0));

endmodule

bind lsm_unit lsm_unit_chk i_lsm_unit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data)
);

// File: tb/test_lsm_unit.sv
module test_lsm_unit;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [4:0]   req_op = '0;
    logic [31:0]  req_base = '0;
    logic [7:0]   req_off0 = '0;
    logic [7:0]   req_off1 = '0;
    logic [127:0] req_data0 = '0;
    logic [127:0] req_data1 = '0;
    logic         rsp_valid;
    logic         rsp_err;
    logic [127:0] rsp_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [7:0] mdl [DEPTH];

    always #2 clk = ~clk;

    lsm_unit #(.AW(AW)) i_lsm_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_base(req_base), .req_off0(req_off0), .req_off1(req_off1),
        .req_data0(req_data0), .req_data1(req_data1),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    function automatic int baddr(input logic [31:0] b, input logic [7:0] o, input int sc, input int k);
        logic [31:0] t;
        t = b + 32'(o) * 32'(sc) + 32'(k);
        return int'(t % DEPTH);
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        if (op > 5'd15)                    return "R9";
        if (op <= 5'd3)                    return "R3";
        if (op <= 5'd6)                    return "R5";
        if (op <= 5'd8)                    return "R7";
        if (op <= 5'd10)                   return "R4";
        if (op <= 5'd13)                   return "R10";
        return "R8";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: compute expected response and update model memory
    task automatic model(input logic [4:0] op, input logic [31:0] b, input logic [7:0] o0,
                         input logic [7:0] o1, input logic [127:0] d0, input logic [127:0] d1,
                         output logic [127:0] e, output bit err);
        int n;
        e = '0;
        err = 1'b0;
        case (op)
            5'd0: e[7:0] = mdl[baddr(b, o0, 1, 0)];
            5'd1: e[31:0] = 32'(signed'(mdl[baddr(b, o0, 1, 0)]));
            5'd2: e[15:0] = {mdl[baddr(b, o0, 1, 1)], mdl[baddr(b, o0, 1, 0)]};
            5'd3: e[31:0] = 32'(signed'({mdl[baddr(b, o0, 1, 1)], mdl[baddr(b, o0, 1, 0)]}));
            5'd4, 5'd5, 5'd6: begin
                n = (op == 5'd4) ? 4 : (op == 5'd5) ? 8 : 16;
                for (int k = 0; k < n; k++) e[8*k +: 8] = mdl[baddr(b, o0, 1, k)];
            end
            5'd7, 5'd8: begin
                n = (op == 5'd7) ? 4 : 8;
                for (int k = 0; k < n; k++) begin
                    e[8*k +: 8]     = mdl[baddr(b, o0, n, k)];
                    e[8*(k+n) +: 8] = mdl[baddr(b, o1, n, k)];
                end
            end
            5'd9, 5'd10, 5'd11, 5'd12, 5'd13: begin
                n = (op == 5'd9) ? 1 : (op == 5'd10) ? 2 : (op == 5'd11) ? 4 : (op == 5'd12) ? 8 : 16;
                for (int k = 0; k < n; k++) mdl[baddr(b, o0, 1, k)] = d0[8*k +: 8];
            end
            5'd14, 5'd15: begin
                n = (op == 5'd14) ? 4 : 8;
                for (int k = 0; k < n; k++) mdl[baddr(b, o0, n, k)] = d0[8*k +: 8];
                for (int k = 0; k < n; k++) mdl[baddr(b, o1, n, k)] = d1[8*k +: 8];
            end
            default: err = 1'b1;
        endcase
    endtask

    task automatic run_op(input logic [4:0] op, input logic [31:0] b, input logic [7:0] o0,
                          input logic [7:0] o1, input logic [127:0] d0, input logic [127:0] d1,
                          input string tag, output logic [127:0] got);
        logic [127:0] e;
        bit err;
        model(op, b, o0, o1, d0, d1, e, err);
        @(negedge clk);
        check(req_ready === 1'b1, "R1 ready before request", 128'(req_ready), 128'd1);
        req_valid = 1'b1; req_op = op; req_base = b; req_off0 = o0; req_off1 = o1;
        req_data0 = d0; req_data1 = d1;
        @(negedge clk);
        got = rsp_data;
        check(rsp_valid === 1'b1 && req_ready === 1'b0, "R1 response cycle",
              128'({rsp_valid, req_ready}), 128'b10);
        check(rsp_data === e && rsp_err === err, tag, rsp_data, e);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 response ends",
              128'({rsp_valid, req_ready}), 128'b01);
    endtask

    initial begin
        logic [127:0] got;
        logic [127:0] r0, r1;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 reset state",
              128'({rsp_valid, req_ready}), 128'b01);
        rst_n = 1'b1;

        // Fill memory with a known pattern (R5 16-byte stores)
        for (int i = 0; i < DEPTH / 16; i++) begin
            r0 = {$urandom, $urandom, $urandom, $urandom};
            run_op(5'd13, 32'(16 * i), 8'd0, 8'd0, r0, '0, "R10", got);
        end

        // R5: little-endian dword placement
        run_op(5'd13, 32'd0, 8'd0, 8'd0, 128'h44444444_33333333_22222222_11111111, '0, "R10", got);
        run_op(5'd6, 32'd0, 8'd0, 8'd0, '0, '0, "R5", got);
        check(got === 128'h44444444_33333333_22222222_11111111, "R5 dword order", got,
              128'h44444444_33333333_22222222_11111111);

        // R7: 8-byte dual load, offsets 0 and 1, no overlap
        run_op(5'd8, 32'd0, 8'd0, 8'd1, '0, '0, "R7", got);
        check(got === 128'h44444444_33333333_22222222_11111111, "R7 no overlap", got,
              128'h44444444_33333333_22222222_11111111);

        // R6: 4-byte dual load offsets 2 and 3 -> bytes 8 and 12
        run_op(5'd7, 32'd0, 8'd2, 8'd3, '0, '0, "R6", got);
        check(got[63:0] === 64'h44444444_33333333, "R6 scale by four", got, 128'h44444444_33333333);

        // R4: byte store leaves neighbours
        run_op(5'd11, 32'd100, 8'd0, 8'd0, 128'hAABBCCDD, '0, "R10", got);
        run_op(5'd9, 32'd100, 8'd1, 8'd0, 128'h5555_0000_1211, '0, "R4", got);
        run_op(5'd4, 32'd100, 8'd0, 8'd0, '0, '0, "R4", got);
        check(got === 128'hAABB11DD, "R4 byte merge", got, 128'hAABB11DD);
        run_op(5'd10, 32'd100, 8'd2, 8'd0, 128'h9999_7766, '0, "R4", got);
        run_op(5'd4, 32'd100, 8'd0, 8'd0, '0, '0, "R4", got);
        check(got === 128'h776611DD, "R4 halfword merge", got, 128'h776611DD);

        // R3: sign and zero extension
        run_op(5'd9, 32'd200, 8'd0, 8'd0, 128'h80, '0, "R4", got);
        run_op(5'd1, 32'd200, 8'd0, 8'd0, '0, '0, "R3", got);
        check(got === 128'hFFFFFF80, "R3 signed byte", got, 128'hFFFFFF80);
        run_op(5'd0, 32'd200, 8'd0, 8'd0, '0, '0, "R3", got);
        check(got === 128'h80, "R3 unsigned byte", got, 128'h80);
        run_op(5'd10, 32'd202, 8'd0, 8'd0, 128'h8001, '0, "R4", got);
        run_op(5'd3, 32'd202, 8'd0, 8'd0, '0, '0, "R3", got);
        check(got === 128'hFFFF8001, "R3 signed halfword", got, 128'hFFFF8001);

        // R2: wrap past the top, high base bits ignored
        run_op(5'd11, 32'h0010_0000 + 32'(DEPTH - 2), 8'd0, 8'd0, 128'hDEADBEEF, '0, "R2", got);
        run_op(5'd5, 32'(DEPTH - 4), 8'd2, 8'd0, '0, '0, "R2", got);
        check(got[31:0] === 32'hDEADBEEF, "R2 wrapped dword", got, 128'hDEADBEEF);

        // R8: equal offsets, element 1 wins; also near the top with wrap
        run_op(5'd14, 32'd300, 8'd3, 8'd3, 128'h11112222, 128'h33334444, "R8", got);
        run_op(5'd4, 32'd312, 8'd0, 8'd0, '0, '0, "R8", got);
        check(got === 128'h33334444, "R8 overlap keeps element1", got, 128'h33334444);
        run_op(5'd15, 32'(DEPTH - 4), 8'd0, 8'd0, 128'h0123456789ABCDEF, 128'hFEDCBA9876543210, "R8", got);
        run_op(5'd5, 32'(DEPTH - 4), 8'd0, 8'd0, '0, '0, "R8", got);
        check(got === 128'hFEDCBA9876543210, "R8 wrapped overlap", got, 128'hFEDCBA9876543210);

        // R6: large scaled offset wraps
        run_op(5'd8, 32'd0, 8'd255, 8'd128, '0, '0, "R6", got);

        // R9: unsupported opcode leaves memory unchanged
        run_op(5'd20, 32'd100, 8'd0, 8'd0, 128'h0, '0, "R9", got);
        run_op(5'd31, 32'd100, 8'd0, 8'd1, '1, '1, "R9", got);
        run_op(5'd4, 32'd100, 8'd0, 8'd0, '0, '0, "R9", got);
        check(got === 128'h776611DD, "R9 memory unchanged", got, 128'h776611DD);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [4:0] op;
            int unsigned r;
            r = $urandom % 20;
            op = (r < 16) ? 5'(r) : 5'(16 + ($urandom % 16));
            r0 = {$urandom, $urandom, $urandom, $urandom};
            r1 = {$urandom, $urandom, $urandom, $urandom};
            run_op(op, $urandom, 8'($urandom), 8'($urandom), r0, r1, tag_of(op), got);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule